// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs single read or write transfers to memory or I/O space on an external bus where the low address byte and the data byte use the same pins. A requester hands over a transfer in one cycle: a 16-bit address, a direction, a space select, an opcode-fetch flag and the write byte. The controller then runs the transfer as a fixed sequence of T-states.

In the first T-state it drives the low address on the shared pins and pulses an address latch strobe so that an external latch can hold the low address. In the second T-state it asserts an active-low read or write strobe and samples a ready input. Each low sample adds one wait state. In the last T-state it releases the strobe, presents the captured read byte and pulses `done`. A space line and two status bits describe the transfer for the whole time it runs.

Between transfers an external master may ask for the bus. The controller then floats every bus output and raises an acknowledge. It never grants the bus in the middle of a transfer.

Top module: `mbc_bus_ctrl`

## Requirements
- R1: Out of reset the controller is idle: `rd_n`=1, `wr_n`=1, `ale`=0, `ad_oe`=0, `done`=0, `hlda`=0, `io_m`=0, `s1`/`s0`=00, `rdata`=0, `bus_oe`=1, and `req_ready`=1 while `hold_in` is low.
- R2: A request taken on a clock edge (`req_valid` and `req_ready` both high) starts T1 in the next cycle. During T1 and only then, `ale`=1, `ad_oe`=1, `ad_out` holds address bits 7:0, and `addr_hi` holds address bits 15:8 for the whole transfer.
- R3: The strobes are active low. A read drives `rd_n`=0 and a write drives `wr_n`=0 from T2 through any wait states. Both strobes are high in T1, T3 and when no transfer runs, and they are never low together.
- R4: `io_m` is 1 for an I/O transfer and 0 for a memory transfer, held from T1 to T3, and 0 when no transfer runs.
- R5: The status pair {`s1`,`s0`} is 10 for a read, 01 for a write and 11 for an opcode fetch, held from T1 to T3, and 00 when no transfer runs. A fetch is always a memory read: `req_write` and `req_io` are ignored when `req_fetch` is 1.
- R6: In a write, the shared pins carry the write byte (`ad_oe`=1) from T2 through T3. In a read, `ad_oe`=0 from T2 through T3.
- R7: When `ready_in` is high at the end of T2, a transfer lasts exactly three cycles (T1, T2, T3), and `done` is high for the single T3 cycle.
- R8: Each clock edge of T2 or a wait state with `ready_in` low adds one wait state with the strobe held low. The read byte is taken from `ad_in` on the edge where the strobe phase ends, appears on `rdata` in T3, and stays unchanged until the next read captures.
- R9: A `hold_in` seen while idle raises `hlda` in the next cycle. While `hlda`=1, `bus_oe`=0 and `ad_oe`=0. `hlda` falls in the cycle after `hold_in` is seen low. A hold raised during a transfer is granted only after T3 and the following idle cycle.
- R10: `req_ready` is 1 only when idle with `hold_in` low. A `req_valid` seen at any other time is ignored and starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 16 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_fetch | input | 1 | Opcode fetch (memory read) |
| req_wdata | input | 8 | Write byte |
| rdata | output | 8 | Captured read byte |
| done | output | 1 | Transfer completes (T3) |
| addr_hi | output | 8 | High address byte |
| bus_oe | output | 1 | Enable for high address, strobes and status |
| ad_out | output | 8 | Shared pins, driven value |
| ad_oe | output | 1 | Shared pins output enable |
| ad_in | input | 8 | Shared pins, sensed value |
| ale | output | 1 | Address latch strobe, high in T1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 = I/O, 0 = memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| ready_in | input | 1 | Device ready, low inserts wait states |
| hold_in | input | 1 | External bus request |
| hlda | output | 1 | Bus granted to external master |

## Verification
The bench drives holds raised in the middle of a transfer. A controller that granted the bus at once would float `rd_n` or the shared pins while a device still drives or samples them, and `hlda` would rise too early. It also sends opcode fetches with `req_write` and `req_io` set, which catch a controller that lets those inputs leak into the strobe, the status pair or `io_m`. Long and short runs of low `ready_in` check where the read byte is captured: a controller that captured one edge early or late returns a byte the bench no longer drives, and a wrong wait count shows up as a wrong transfer length. A bus turnaround fault would show as `ad_oe` high while `rd_n` is low, or as the write byte missing in T3.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_T1,
      ST_T2,
      ST_TW,
      ST_T3,
      ST_HOLD
   } mbc_state_t;

   localparam logic [1:0] STAT_NONE  = 2'b00;
   localparam logic [1:0] STAT_READ  = 2'b10;
   localparam logic [1:0] STAT_WRITE = 2'b01;
   localparam logic [1:0] STAT_FETCH = 2'b11;

   function automatic logic [1:0] status_code(input logic wr, input logic fetch);
      if (fetch)   return STAT_FETCH;
      else if (wr) return STAT_WRITE;
      else         return STAT_READ;
   endfunction

   function automatic logic in_cycle(input mbc_state_t st);
      return (st == ST_T1) || (st == ST_T2) || (st == ST_TW) || (st == ST_T3);
   endfunction

endpackage

// File: rtl/mbc_fsm.sv
module mbc_fsm
   import mbc_pkg::*;
#(
   parameter bit USE_READY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       hold_in,
   input  logic       ready_in,
   output mbc_state_t state,
   output logic       req_ready,
   output logic       accept,
   output logic       capture
);

   logic       ready_eff;
   mbc_state_t state_nx;

   generate
      if (USE_READY) begin : g_ready
         assign ready_eff = ready_in;
      end else begin : g_noready
         assign ready_eff = 1'b1;
      end
   endgenerate

   assign req_ready = (state == ST_IDLE) && !hold_in;
   assign accept    = req_ready && req_valid;
   assign capture   = ((state == ST_T2) || (state == ST_TW)) && ready_eff;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: begin
            if (hold_in)        state_nx = ST_HOLD;
            else if (req_valid) state_nx = ST_T1;
         end
         ST_T1:   state_nx = ST_T2;
         ST_T2,
         ST_TW:   state_nx = ready_eff ? ST_T3 : ST_TW;
         ST_T3:   state_nx = ST_IDLE;
         ST_HOLD: if (!hold_in) state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   // R9
   hold_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_cycle(state) |=> (state != ST_HOLD));

   // R8
   wait_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((state == ST_T2) || (state == ST_TW)) && !ready_eff) |=> (state == ST_TW));

   // R10
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> (state != ST_T1));

endmodule

// File: rtl/mbc_reqreg.sv
module mbc_reqreg #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_io,
   input  logic              req_fetch,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] ad_in,
   output logic [ADDR_W-1:0] lat_addr,
   output logic              lat_wr,
   output logic              lat_io,
   output logic              lat_fetch,
   output logic [DATA_W-1:0] lat_wdata,
   output logic [DATA_W-1:0] rdata
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_addr  <= '0;
         lat_wr    <= 1'b0;
         lat_io    <= 1'b0;
         lat_fetch <= 1'b0;
         lat_wdata <= '0;
      end else if (accept) begin
         lat_addr  <= req_addr;
         lat_wr    <= req_write && !req_fetch;
         lat_io    <= req_io && !req_fetch;
         lat_fetch <= req_fetch;
         lat_wdata <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 rdata <= '0;
      else if (capture && !lat_wr) rdata <= ad_in;
   end

   // R8
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(rdata));

endmodule

// File: rtl/mbc_drive.sv
module mbc_drive
   import mbc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   localparam int HI_W  = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mbc_state_t        state,
   input  logic [ADDR_W-1:0] lat_addr,
   input  logic              lat_wr,
   input  logic              lat_io,
   input  logic              lat_fetch,
   input  logic [DATA_W-1:0] lat_wdata,
   output logic [HI_W-1:0]   addr_hi,
   output logic              bus_oe,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic              io_m,
   output logic [1:0]        status,
   output logic              done,
   output logic              hlda
);

   logic strobe_ph;
   logic active;

   assign active    = in_cycle(state);
   assign strobe_ph = (state == ST_T2) || (state == ST_TW);

   always_comb begin
      addr_hi = lat_addr[ADDR_W-1:DATA_W];
      bus_oe  = (state != ST_HOLD);
      hlda    = (state == ST_HOLD);
      ale     = (state == ST_T1);
      done    = (state == ST_T3);
      rd_n    = !(strobe_ph && !lat_wr);
      wr_n    = !(strobe_ph && lat_wr);
      io_m    = active && lat_io;
      status  = active ? status_code(lat_wr, lat_fetch) : STAT_NONE;
      ad_oe   = 1'b0;
      ad_out  = '0;
      if (state == ST_T1) begin
         ad_oe  = 1'b1;
         ad_out = lat_addr[DATA_W-1:0];
      end else if ((strobe_ph || (state == ST_T3)) && lat_wr) begin
         ad_oe  = 1'b1;
         ad_out = lat_wdata;
      end
   end

   // R3
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   // R6
   rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe);

   // R2
   ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> (!ale && (!rd_n || !wr_n)));

   // R9
   hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hlda |-> (!bus_oe && !ad_oe && rd_n && wr_n));

endmodule

// File: rtl/mbc_bus_ctrl.sv
module mbc_bus_ctrl
   import mbc_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter bit USE_READY = 1'b1,
   localparam int HI_W     = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_io,
   input  logic              req_fetch,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              done,
   output logic [HI_W-1:0]   addr_hi,
   output logic              bus_oe,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   input  logic [DATA_W-1:0] ad_in,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic              io_m,
   output logic              s1,
   output logic              s0,
   input  logic              ready_in,
   input  logic              hold_in,
   output logic              hlda
);

   generate
      if (ADDR_W <= DATA_W) begin : g_bad_width
         $error("mbc_bus_ctrl: ADDR_W must exceed DATA_W");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("mbc_bus_ctrl: DATA_W must be positive");
      end
   endgenerate

   mbc_state_t        state;
   logic              accept;
   logic              capture;
   logic [ADDR_W-1:0] lat_addr;
   logic              lat_wr;
   logic              lat_io;
   logic              lat_fetch;
   logic [DATA_W-1:0] lat_wdata;
   logic [1:0]        status;

   mbc_fsm #(.USE_READY(USE_READY)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .hold_in   (hold_in),
      .ready_in  (ready_in),
      .state     (state),
      .req_ready (req_ready),
      .accept    (accept),
      .capture   (capture)
   );

   mbc_reqreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_write (req_write),
      .req_io    (req_io),
      .req_fetch (req_fetch),
      .req_wdata (req_wdata),
      .ad_in     (ad_in),
      .lat_addr  (lat_addr),
      .lat_wr    (lat_wr),
      .lat_io    (lat_io),
      .lat_fetch (lat_fetch),
      .lat_wdata (lat_wdata),
      .rdata     (rdata)
   );

   mbc_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
      .clk       (clk),
      .rst_n     (rst_n),
      .state     (state),
      .lat_addr  (lat_addr),
      .lat_wr    (lat_wr),
      .lat_io    (lat_io),
      .lat_fetch (lat_fetch),
      .lat_wdata (lat_wdata),
      .addr_hi   (addr_hi),
      .bus_oe    (bus_oe),
      .ad_out    (ad_out),
      .ad_oe     (ad_oe),
      .ale       (ale),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .io_m      (io_m),
      .status    (status),
      .done      (done),
      .hlda      (hlda)
   );

   assign s1 = status[1];
   assign s0 = status[0];

   // R7
   done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(!rd_n || !wr_n) && rd_n && wr_n));

   // R4
   space_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($stable(io_m) && $stable({s1, s0})));

   // R10
   no_take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> !ale);

endmodule

// File: tb/mbc_bus_ctrl_bench.sv
module mbc_bus_ctrl_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        req_io = 1'b0;
   logic        req_fetch = 1'b0;
   logic [7:0]  req_wdata = '0;
   logic [7:0]  ad_in = '0;
   logic        ready_in = 1'b1;
   logic        hold_in = 1'b0;

   logic        req_ready, done, bus_oe, ad_oe, ale, rd_n, wr_n, io_m, s1, s0, hlda;
   logic [7:0]  rdata, addr_hi, ad_out;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbc_bus_ctrl u_mbc_bus_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_io(req_io),
      .req_fetch(req_fetch), .req_wdata(req_wdata), .rdata(rdata), .done(done),
      .addr_hi(addr_hi), .bus_oe(bus_oe), .ad_out(ad_out), .ad_oe(ad_oe),
      .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m),
      .s1(s1), .s0(s0), .ready_in(ready_in), .hold_in(hold_in), .hlda(hlda)
   );

   // reference model: phase 0 idle, 1 address, 2 strobe (incl. waits), 3 end, 4 granted
   int          m_phase = 0;
   logic [15:0] m_addr = '0;
   logic        m_wr = 0, m_io = 0, m_fetch = 0;
   logic [7:0]  m_wdata = '0, m_rdata = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_addr = '0; m_wr = 0; m_io = 0; m_fetch = 0;
         m_wdata = '0; m_rdata = '0;
      end else begin
         case (m_phase)
            0: if (hold_in) m_phase = 4;
               else if (req_valid) begin
                  m_phase = 1; m_addr = req_addr; m_fetch = req_fetch;
                  m_wr = req_write && !req_fetch; m_io = req_io && !req_fetch;
                  m_wdata = req_wdata;
               end
            1: m_phase = 2;
            2: if (ready_in) begin
                  if (!m_wr) m_rdata = ad_in;
                  m_phase = 3;
               end
            3: m_phase = 0;
            default: if (!hold_in) m_phase = 0;
         endcase
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      logic act_on;
      logic [1:0] st;
      act_on = (m_phase >= 1) && (m_phase <= 3);
      st = !act_on ? 2'b00 : m_fetch ? 2'b11 : m_wr ? 2'b01 : 2'b10;
      chk("R2 ale", ale, m_phase == 1);
      chk("R3 rd_n", rd_n, !(m_phase == 2 && !m_wr));
      chk("R3 wr_n", wr_n, !(m_phase == 2 && m_wr));
      chk("R4 io_m", io_m, act_on && m_io);
      chk("R5 status", {s1, s0}, st);
      chk("R6 ad_oe", ad_oe, (m_phase == 1) || ((m_phase == 2 || m_phase == 3) && m_wr));
      if (m_phase == 1) chk("R2 ad_out addr", ad_out, m_addr[7:0]);
      else if (ad_oe)   chk("R6 ad_out data", ad_out, m_wdata);
      if (act_on)       chk("R2 addr_hi", addr_hi, m_addr[15:8]);
      chk("R7 done", done, m_phase == 3);
      chk("R8 rdata", rdata, m_rdata);
      chk("R9 hlda", hlda, m_phase == 4);
      chk("R9 bus_oe", bus_oe, m_phase != 4);
      chk("R10 req_ready", req_ready, (m_phase == 0) && !hold_in);
   endtask

   task automatic cyc();
      @(negedge clk);
      compare_all();
   endtask

   // directed transfer; returns cycles from accept to done
   task automatic run_req(input logic [15:0] a, input logic w, input logic io,
                          input logic f, input logic [7:0] wd, input logic [7:0] rd_val,
                          input int waits, input logic hold_mid, output int len);
      int left;
      left = waits;
      req_valid = 1; req_addr = a; req_write = w; req_io = io; req_fetch = f;
      req_wdata = wd; ready_in = 1; ad_in = 8'h00;
      cyc();
      req_valid = 0; req_addr = ~a; req_wdata = ~wd;
      len = 1;
      if (hold_mid) hold_in = 1;
      while (!done && len < 50) begin
         if (!rd_n || !wr_n) begin
            ready_in = (left == 0);
            ad_in = (left == 0) ? rd_val : ~rd_val;
            if (left > 0) left--;
         end
         cyc();
         len++;
      end
      ready_in = 1;
   endtask

   initial begin
      int len;
      repeat (3) @(negedge clk);
      rst_n = 1;
      cyc();
      // R1 reset state
      chk("R1 rd_n", rd_n, 1); chk("R1 wr_n", wr_n, 1); chk("R1 ale", ale, 0);
      chk("R1 ad_oe", ad_oe, 0); chk("R1 done", done, 0); chk("R1 hlda", hlda, 0);
      chk("R1 status", {io_m, s1, s0}, 0); chk("R1 rdata", rdata, 0);
      chk("R1 req_ready", req_ready, 1);

      run_req(16'h83A5, 0, 0, 0, 8'h00, 8'h5C, 0, 0, len);
      chk("R7 read length", len, 3);
      chk("R8 read data", rdata, 8'h5C);
      cyc();
      run_req(16'h0042, 1, 1, 0, 8'hC3, 8'h00, 0, 0, len);
      chk("R7 io write length", len, 3);
      cyc();
      run_req(16'h1234, 1, 1, 1, 8'hEE, 8'h9A, 0, 0, len);
      chk("R5 fetch read data", rdata, 8'h9A);
      cyc();
      run_req(16'hFF01, 0, 1, 0, 8'h00, 8'h17, 2, 0, len);
      chk("R8 two waits length", len, 5);
      chk("R8 late data", rdata, 8'h17);
      cyc();
      run_req(16'h7F80, 1, 0, 0, 8'h3C, 8'h00, 1, 0, len);
      chk("R8 one wait length", len, 4);
      chk("R8 rdata kept over write", rdata, 8'h17);
      cyc();

      // R9 hold while idle
      hold_in = 1; req_valid = 1;
      cyc();
      chk("R9 hlda granted", hlda, 1);
      chk("R10 req blocked", req_ready, 0);
      cyc();
      req_valid = 0; hold_in = 0;
      cyc();
      chk("R9 hlda released", hlda, 0);

      // R9 hold raised mid-transfer
      run_req(16'h2000, 0, 0, 0, 8'h00, 8'hA1, 1, 1, len);
      chk("R9 mid hold length", len, 4);
      chk("R9 no grant in T3", hlda, 0);
      cyc();
      chk("R9 no grant idle", hlda, 0);
      cyc();
      chk("R9 grant after cycle", hlda, 1);
      hold_in = 0;
      cyc();

      // random traffic against the model
      for (int i = 0; i < 3000; i++) begin
         req_valid = ($urandom % 3) == 0;
         req_addr  = 16'($urandom);
         req_write = 1'($urandom);
         req_io    = 1'($urandom);
         req_fetch = ($urandom % 5) == 0;
         req_wdata = 8'($urandom);
         ad_in     = 8'($urandom);
         ready_in  = ($urandom % 4) != 0;
         if (($urandom % 25) == 0) hold_in = ~hold_in;
         cyc();
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired, run hung");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule